// File: doc/BRIEF.md
# Serial Register Access Port for Four-Line Transceiver

This block is the slave end of a three-wire serial control link. A host microcontroller uses it to reach the per-line timeslot and control registers of a four-line transceiver, and to read one status register that all lines share. The host drives chip select low and supplies sixteen serial clocks per transfer. It sends an address byte and then a data byte. During the same frame the block shifts sixteen bits back. Every access is full duplex. A write returns the value the register held before the write. A readback-only access returns the value and leaves the register as it was.

Chip select, serial clock and serial input are brought into the system clock domain through a synchronizer. Their edges are detected there. This lets the port sit in a chip whose fabric runs faster than the host's serial clock. The serial output comes with a separate enable, which drives a tri-state pad. A latched, active-low interrupt tells the host that a line status bit has changed. The bipolar-violation bit is excluded from this. The interrupt clears as soon as the host starts a read of the status register.

Top module: `mwr_serial_port`

## Requirements
- R1: A frame is the run of serial clock rising edges while `cs_n` is low. `sdi` is sampled on each rising edge, bit 7 first. The first 8 bits form the address byte and the next 8 bits form the data byte.
- R2: `sdo` changes only after falling serial clock edges. For the first 8 bits of a frame it is 0. From the 8th falling edge onward it carries the returned byte, bit 7 first. That byte is the addressed register's contents, taken when the 8th address bit is sampled.
- R3: `sdo_en` is high during a frame. It goes low within SYNC_STAGES+2 system clocks after `cs_n` rises. While `sdo_en` is low, `sdo` is 0.
- R4: Address bits 7:4 select the line, 0 to 3. Address bits 3:1 select the register: 000 transmit D slot, 001 transmit B1 slot, 010 transmit B2 slot, 011 receive D slot, 100 receive B1 slot, 101 receive B2 slot, 111 line control. Each register stores 8 bits independently of every other register.
- R5: Address bit 0 = 0 is a write: the data byte replaces the register and the old value is returned. Address bit 0 = 1 is readback only: the register keeps its value whatever the data byte is.
- R6: A write commits only if at least 16 rising edges arrived before `cs_n` rose. A frame with fewer edges changes no register.
- R7: The following addresses are unused: upper nibble 4 to E, upper nibble F except 0xFF, and register code 110 on any line. An unused address returns 0x00, and a write to it changes no register.
- R8: Address 0xFF returns the status register. The status register holds `stat_in` as sampled one system clock earlier.
- R9: `irq_n` goes low in the clock after any `stat_in` bit other than bit BPV_BIT changes. It stays low until it is cleared.
- R10: `irq_n` returns high when the 8th address bit of a frame addressed to 0xFF is sampled. Frames to other addresses leave it low.
- R11: A change confined to `stat_in` bit BPV_BIT (bit 0 by default) does not pull `irq_n` low.
- R12: After reset, every register reads 0x00, `irq_n` is high and `sdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run at least several times faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Output enable for the `sdo` tri-state pad |
| stat_in | input | 8 | Line status bits that feed the shared status register |
| irq_n | output | 1 | Latched active-low interrupt |

## Verification
Most internal faults reach the pins within one frame. If the bit counter is off by one, the returned byte appears shifted or the address is mis-assembled, and the next readback shows the wrong value. A wrong decode of the line or register field shows up only when another register is read back. For that reason every slot on every line gets a distinct value and all slots are read back, and the aliases through unused addresses are probed. A stuck interrupt latch or a wrong status mask is visible on `irq_n` within two system clocks of a status change. A missing clear is visible right after the status read frame ends.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BITS  = 2 * BYTE_W;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);
    localparam int SLOTS       = 8;
    localparam logic [2:0] UNUSED_SLOT = 3'b110;
    localparam logic [BYTE_W-1:0] STATUS_ADDR = 8'hFF;

    typedef struct packed {
        logic              sclk_prev;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-2:0] in_sh;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] out_sh;
        logic              sdo;
    } ser_state_t;

    localparam ser_state_t SER_RESET = '0;
endpackage

// File: rtl/mwr_sync.sv
module mwr_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            always_comb stage_d = d_i;
        end else begin : g_next
            always_comb stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mwr_regfile.sv
module mwr_regfile
    import mwr_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:1]        raddr_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              we_i,
    input  logic [7:1]        waddr_i,
    input  logic [BYTE_W-1:0] wdata_i
);
    localparam int LIDX_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0][SLOTS-1:0][BYTE_W-1:0] mem_d, mem_q;

    function automatic logic slot_hit(input logic [7:1] a);
        return (int'(a[7:4]) < NUM_LINES) && (a[3:1] != UNUSED_SLOT);
    endfunction

    always_comb begin
        mem_d = mem_q;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (we_i && slot_hit(waddr_i) && int'(waddr_i[7:4]) == l
                    && int'(waddr_i[3:1]) == s) begin
                    mem_d[l][s] = wdata_i;
                end
            end
        end
        rdata_o = '0;
        if (slot_hit(raddr_i)) rdata_o = mem_q[raddr_i[4 +: LIDX_W]][raddr_i[3:1]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/mwr_status.sv
module mwr_status
    import mwr_pkg::*;
#(
    parameter int BPV_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] stat_i,
    input  logic              clr_i,
    output logic [BYTE_W-1:0] stat_o,
    output logic              irq_o
);
    localparam logic [BYTE_W-1:0] WATCH_MASK = ~(BYTE_W'(1) << BPV_BIT);

    typedef struct packed {
        logic [BYTE_W-1:0] stat;
        logic              irq;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_i;
        if (|((stat_i ^ st_q.stat) & WATCH_MASK)) st_d.irq = 1'b1;
        else if (clr_i)                          st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/mwr_serial_port.sv
module mwr_serial_port
    import mwr_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BPV_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    input  logic [BYTE_W-1:0] stat_in,
    output logic              irq_n
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] OUT_FIRST = CNT_W'(BYTE_W);

    logic [2:0] pins_s;
    logic cs_s, sclk_s, sdi_s;

    mwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sclk, sdi}),
        .q_o   (pins_s)
    );
    assign {cs_s, sclk_s, sdi_s} = pins_s;

    ser_state_t q, d;
    logic [BYTE_W-1:0] addr_now, rf_rdata, stat_val, rd_byte;
    logic rf_we, stat_clr, irq;

    assign addr_now = {q.in_sh, sdi_s};
    assign rd_byte  = (addr_now == STATUS_ADDR) ? stat_val : rf_rdata;

    mwr_regfile #(.NUM_LINES(NUM_LINES)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_i (addr_now[7:1]),
        .rdata_o (rf_rdata),
        .we_i    (rf_we),
        .waddr_i (q.addr[7:1]),
        .wdata_i (q.data)
    );

    mwr_status #(.BPV_BIT(BPV_BIT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_in),
        .clr_i  (stat_clr),
        .stat_o (stat_val),
        .irq_o  (irq)
    );

    always_comb begin
        logic rise, fall;
        d        = q;
        rf_we    = 1'b0;
        stat_clr = 1'b0;
        rise     = sclk_s & ~q.sclk_prev;
        fall     = ~sclk_s & q.sclk_prev;
        d.sclk_prev = sclk_s;
        if (cs_s) begin
            if (q.active && q.cnt == FULL && !q.addr[0]) rf_we = 1'b1;
            d.active = 1'b0;
            d.cnt    = '0;
            d.sdo    = 1'b0;
        end else begin
            d.active = 1'b1;
            if (rise && q.cnt != FULL) begin
                d.in_sh = {q.in_sh[BYTE_W-3:0], sdi_s};
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == ADDR_LAST) begin
                    d.addr   = addr_now;
                    d.out_sh = rd_byte;
                    stat_clr = (addr_now == STATUS_ADDR);
                end
                if (q.cnt == DATA_LAST) d.data = addr_now;
            end
            if (fall) begin
                if (q.cnt >= OUT_FIRST && q.cnt <= DATA_LAST) begin
                    d.sdo    = q.out_sh[BYTE_W-1];
                    d.out_sh = {q.out_sh[BYTE_W-2:0], 1'b0};
                end else begin
                    d.sdo = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SER_RESET;
        else        q <= d;
    end

    assign sdo    = q.sdo;
    assign sdo_en = q.active;
    assign irq_n  = ~irq;
endmodule

// File: rtl/mwr_serial_port_chk.sv
module mwr_serial_port_chk #(
    parameter int BPV_BIT = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       sdo_en,
    input logic [7:0] stat_in,
    input logic       irq_n
);
    localparam logic [7:0] WATCH = ~(8'(1) << BPV_BIT);

    logic [2:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 7)  cyc <= cyc + 1'b1;
    end

    a_r3_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);

    a_r3_sdo_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);

    // R9 and R11: a falling interrupt needs a watched status bit to have changed
    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3 && $fell(irq_n)) |-> ((($past(stat_in) ^ $past(stat_in, 2)) & WATCH) != 8'h00));

    a_r9_irq_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 1 && !$past(irq_n) && !$past(sdo_en)) |-> !irq_n);

    a_r10_clear_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2 && $rose(irq_n)) |-> $past(sdo_en));
endmodule

bind mwr_serial_port mwr_serial_port_chk #(.BPV_BIT(BPV_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .stat_in (stat_in),
    .irq_n   (irq_n)
);

// File: tb/mwr_serial_port_test.sv
module mwr_serial_port_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_en, irq_n;
    logic [7:0] stat_in = 8'h00;

    int checks = 0;
    int fails = 0;
    bit en_ok;

    mwr_serial_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .stat_in(stat_in), .irq_n(irq_n)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] dat, input int nbits,
                        output logic [15:0] got);
        logic [15:0] w;
        w = {a, dat};
        got = '0;
        en_ok = 1'b1;
        cs_n = 1'b0;
        idle(8);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[15-i];
            idle(4);
            got[15-i] = sdo;
            if (sdo_en !== 1'b1) en_ok = 1'b0;
            idle(4);
            sclk = 1'b1;
            idle(8);
            sclk = 1'b0;
        end
        idle(8);
        cs_n = 1'b1;
        sdi = 1'b0;
        idle(12);
    endtask

    function automatic logic [7:0] pattern(input int l, input int s);
        return 8'((l * 16 + s * 3) ^ 8'h5A);
    endfunction

    task automatic t_reset();
        logic [15:0] g;
        check("R12 irq_n after reset", {15'b0, irq_n}, 16'h1);
        check("R12 sdo_en after reset", {15'b0, sdo_en}, 16'h0);
        xfer(8'h0F, 8'h00, 16, g);
        check("R12 ctrl line0 reset value", g, 16'h0000);
        check("R3 sdo_en high through frame", {15'b0, en_ok}, 16'h1);
        check("R3 sdo_en low after frame", {15'b0, sdo_en}, 16'h0);
    endtask

    task automatic t_write_read();
        logic [15:0] g;
        xfer(8'h12, 8'hA5, 16, g);
        check("R5 write returns old, R2 address byte zero", g, 16'h0000);
        xfer(8'h12, 8'h3C, 16, g);
        check("R5 second write returns first value, R1 MSB first", g, 16'h00A5);
        xfer(8'h13, 8'hFF, 16, g);
        check("R5 readback value", g, 16'h003C);
        xfer(8'h13, 8'h00, 16, g);
        check("R5 readback left register unchanged", g, 16'h003C);
    endtask

    task automatic t_all_regs();
        logic [15:0] g;
        int bad = 0;
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 8; s++)
                if (s != 6) xfer(8'(l * 16 + s * 2), pattern(l, s), 16, g);
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 8; s++)
                if (s != 6) begin
                    xfer(8'(l * 16 + s * 2 + 1), 8'h00, 16, g);
                    if (g !== {8'h00, pattern(l, s)}) begin
                        bad++;
                        $display("FAIL R4 line %0d slot %0d actual=%h expected=%h",
                                 l, s, g, {8'h00, pattern(l, s)});
                    end
                end
        checks++;
        if (bad != 0) fails++;
    endtask

    task automatic t_unused();
        logic [15:0] g;
        xfer(8'h4E, 8'h77, 16, g);
        check("R7 line 4 write returns zero", g, 16'h0000);
        xfer(8'h0C, 8'h66, 16, g);
        check("R7 slot 110 write returns zero", g, 16'h0000);
        xfer(8'hFE, 8'h55, 16, g);
        check("R7 address FE returns zero", g, 16'h0000);
        xfer(8'h0D, 8'h00, 16, g);
        check("R7 slot 110 read stays zero", g, 16'h0000);
        xfer(8'h4F, 8'h00, 16, g);
        check("R7 line 4 read stays zero", g, 16'h0000);
        xfer(8'h0F, 8'h00, 16, g);
        check("R7 line0 ctrl untouched by alias", g, {8'h00, pattern(0, 7)});
        xfer(8'h0B, 8'h00, 16, g);
        check("R7 line0 slot 5 untouched", g, {8'h00, pattern(0, 5)});
    endtask

    task automatic t_abort();
        logic [15:0] g;
        xfer(8'h22, 8'h99, 12, g);
        xfer(8'h22, 8'h98, 15, g);
        xfer(8'h23, 8'h00, 16, g);
        check("R6 short frames leave register", g, {8'h00, pattern(2, 1)});
        check("R6 no interrupt from frames", {15'b0, irq_n}, 16'h1);
    endtask

    task automatic t_status();
        logic [15:0] g;
        stat_in = 8'h10;
        idle(3);
        check("R9 irq low after status change", {15'b0, irq_n}, 16'h0);
        idle(40);
        check("R9 irq stays latched", {15'b0, irq_n}, 16'h0);
        xfer(8'h31, 8'h00, 16, g);
        check("R10 other address does not clear", {15'b0, irq_n}, 16'h0);
        xfer(8'hFF, 8'h00, 16, g);
        check("R8 status readback", g, 16'h0010);
        check("R10 status read clears irq", {15'b0, irq_n}, 16'h1);
    endtask

    task automatic t_bpv();
        logic [15:0] g;
        stat_in = 8'h11;
        idle(5);
        check("R11 bpv bit change ignored", {15'b0, irq_n}, 16'h1);
        xfer(8'hFF, 8'h00, 16, g);
        check("R8 status shows bpv bit", g, 16'h0011);
        stat_in = 8'h91;
        idle(3);
        check("R9 high bit change sets irq", {15'b0, irq_n}, 16'h0);
        xfer(8'hFF, 8'h00, 16, g);
        check("R10 clear after second read", {15'b0, irq_n}, 16'h1);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_write_read();
        t_all_regs();
        t_unused();
        t_abort();
        t_status();
        t_bpv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule